// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer with Two-Bit Direction Counters

This block sits beside the fetch stage of a pipelined processor and answers, from the fetch address alone, three questions: is the fetched word a branch, where would it go, and is it expected to be taken. The buffer is a direct-mapped table. A slot is picked by the word-address bits just above the byte offset, and it holds a tag, the precomputed target and a two-bit saturating direction counter. A lookup that matches the tag marks the word as a branch. A lookup that misses means the word is not a branch, and fetch simply continues at the sequential address.

Training comes from the writeback stage. Each resolved branch reports its own address, whether it was taken, and its actual target. A resolved branch that already owns a slot moves its counter one step toward the outcome. A taken branch that has no slot claims one and starts at the weakly-taken state. A not-taken branch without a slot leaves the table alone, so a branch seen for the first time is predicted not taken.

Top module: `btb_predictor`

## Requirements
- R1: With ENTRIES slots, the slot is chosen by fetch address bits [log2(ENTRIES)+1:2] (bits [7:2] for 64 slots), and the remaining upper bits form the tag. A lookup hits only when the slot is valid and its tag equals the fetch tag; two addresses that share a slot but differ in tag never see each other's entry.
- R2: Reset clears every slot, so after reset every lookup misses until new training arrives.
- R3: On a miss, pred_hit = 0, pred_taken = 0, pred_target = 0 and pred_next_pc = fetch_pc + 4.
- R4: A taken resolution for an address with no matching slot writes that slot with the new tag and target and with counter value 2'b10 (weakly taken). From the next cycle, a lookup of that address gives pred_hit = 1, pred_taken = 1, pred_target = the reported target and pred_next_pc = that target. Targets are word aligned, and bits [1:0] of pred_target always read 0.
- R5: A not-taken resolution for an address with no matching slot writes nothing, and the address still misses afterwards.
- R6: For an address with a matching slot, a taken resolution raises the counter by one and a not-taken resolution lowers it by one, saturating at 2'b11 and 2'b00. Counter values 2'b10 and 2'b11 predict taken; 2'b00 and 2'b01 predict not taken.
- R7: From the strongly-taken state, one not-taken resolution leaves the prediction taken and a second one turns it to not taken. The same holds in the other direction from strongly not taken.
- R8: A hit whose counter predicts not taken still reports pred_hit = 1 with the stored target, and pred_next_pc = fetch_pc + 4.
- R9: A taken resolution for an address with a matching slot replaces the stored target with the reported one, even when the counter still predicts not taken afterwards. A not-taken resolution keeps the stored target.
- R10: A taken resolution for a different tag in an occupied slot evicts the old entry. The new address then hits with a fresh weakly-taken counter, and the old address misses.
- R11: A resolution changes lookups only from the cycle after it is presented. A lookup in the same cycle sees the old contents, and with no resolution presented the outputs for a steady fetch address do not change.
- R12: A branch that alternates taken and not taken after allocating at weakly taken is mispredicted on every execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | ADDR_W | Address of the word being fetched |
| pred_hit | output | 1 | Fetched word is a known branch |
| pred_taken | output | 1 | Predicted direction: 1 = taken |
| pred_target | output | ADDR_W | Stored target on a hit, 0 on a miss |
| pred_next_pc | output | ADDR_W | Address fetch should use next |
| wb_valid | input | 1 | A resolved branch is reported this cycle |
| wb_pc | input | ADDR_W | Address of the resolved branch |
| wb_taken | input | 1 | Resolved direction: 1 = taken |
| wb_target | input | ADDR_W | Resolved target address (word aligned) |

## Verification
A corrupted slot shows up at the ports in the first fetch of an address that maps to it. A wrong tag or valid bit flips pred_hit, and a wrong target or counter changes pred_target, pred_taken and pred_next_pc in that same combinational lookup. A counter that steps wrongly is only visible on a later fetch: the first resolution that should have flipped the direction, or failed to flip it, shows it. So the bench runs counters through saturation at both ends and through the two-step hysteresis, and reads the prediction after every resolution. Slot aliasing and eviction, and the one-cycle gap between a resolution and the lookup that sees it, are checked on the cycle they take effect.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Two-bit direction counter
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // Kind of write the training path performs
    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_TRAIN = 2'd1,
        UPD_ALLOC = 2'd2
    } upd_kind_e;

    // Saturating step toward the resolved outcome
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? cur : ctr_t'(cur + 2'd1);
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? cur : ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // Upper half of the counter range predicts taken
    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    // Byte offset within a word carries no information for lookup
    logic unused_byte_off;

    assign idx             = pc[IDX_W+1:2];
    assign tag             = pc[ADDR_W-1:IDX_W+2];
    assign unused_byte_off = ^pc[1:0];
endmodule

// File: rtl/btb_store.sv
module btb_store #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 24,
    parameter int TGT_W   = 30,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    // write port
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [TAG_W-1:0]  w_tag,
    input  logic [TGT_W-1:0]  w_tgt,
    input  btb_pkg::ctr_t     w_ctr,
    // fetch read port
    input  logic [IDX_W-1:0]  rf_idx,
    output logic              rf_valid,
    output logic [TAG_W-1:0]  rf_tag,
    output logic [TGT_W-1:0]  rf_tgt,
    output btb_pkg::ctr_t     rf_ctr,
    // writeback read port
    input  logic [IDX_W-1:0]  rw_idx,
    output logic              rw_valid,
    output logic [TAG_W-1:0]  rw_tag,
    output logic [TGT_W-1:0]  rw_tgt,
    output btb_pkg::ctr_t     rw_ctr
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];
    btb_pkg::ctr_t      ctr_q [ENTRIES];
    logic [ENTRIES-1:0] wsel;

    // One-hot slot select for the write port
    for (genvar g = 0; g < ENTRIES; g++) begin : g_wsel
        assign wsel[g] = we && (w_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                tgt_q[i] <= '0;
                ctr_q[i] <= btb_pkg::CTR_STRONG_NT;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wsel[i]) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= w_tag;
                    tgt_q[i]   <= w_tgt;
                    ctr_q[i]   <= w_ctr;
                end
            end
        end
    end

    // Asynchronous read ports
    assign rf_valid = valid_q[rf_idx];
    assign rf_tag   = tag_q[rf_idx];
    assign rf_tgt   = tgt_q[rf_idx];
    assign rf_ctr   = ctr_q[rf_idx];

    assign rw_valid = valid_q[rw_idx];
    assign rw_tag   = tag_q[rw_idx];
    assign rw_tgt   = tgt_q[rw_idx];
    assign rw_ctr   = ctr_q[rw_idx];
endmodule

// File: rtl/btb_train.sv
module btb_train #(
    parameter int TAG_W = 24,
    parameter int TGT_W = 30
) (
    input  logic                 wb_valid,
    input  logic                 wb_taken,
    input  logic [TAG_W-1:0]     wb_tag,
    input  logic [TGT_W-1:0]     wb_tgt,
    // current slot contents at the resolved address
    input  logic                 cur_valid,
    input  logic [TAG_W-1:0]     cur_tag,
    input  logic [TGT_W-1:0]     cur_tgt,
    input  btb_pkg::ctr_t        cur_ctr,
    // write request
    output logic                 we,
    output logic [TAG_W-1:0]     w_tag,
    output logic [TGT_W-1:0]     w_tgt,
    output btb_pkg::ctr_t        w_ctr,
    output btb_pkg::upd_kind_e   kind
);
    logic owner;

    assign owner = cur_valid && (cur_tag == wb_tag);

    always_comb begin
        kind = btb_pkg::UPD_NONE;
        if (wb_valid) begin
            if (owner) begin
                kind = btb_pkg::UPD_TRAIN;
            end else if (wb_taken) begin
                kind = btb_pkg::UPD_ALLOC;
            end
        end
    end

    always_comb begin
        we    = 1'b0;
        w_tag = wb_tag;
        w_tgt = cur_tgt;
        w_ctr = cur_ctr;
        unique case (kind)
            btb_pkg::UPD_TRAIN: begin
                we    = 1'b1;
                w_tgt = wb_taken ? wb_tgt : cur_tgt;
                w_ctr = btb_pkg::ctr_step(cur_ctr, wb_taken);
            end
            btb_pkg::UPD_ALLOC: begin
                we    = 1'b1;
                w_tgt = wb_tgt;
                w_ctr = btb_pkg::CTR_WEAK_T;
            end
            default: begin
                we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 24,
    localparam int TGT_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [TAG_W-1:0]  fetch_tag,
    input  logic              slot_valid,
    input  logic [TAG_W-1:0]  slot_tag,
    input  logic [TGT_W-1:0]  slot_tgt,
    input  btb_pkg::ctr_t     slot_ctr,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_pc
);
    logic [ADDR_W-1:0] seq_pc;

    assign seq_pc = fetch_pc + ADDR_W'(4);
    assign hit    = slot_valid && (slot_tag == fetch_tag);
    assign taken  = hit && btb_pkg::ctr_says_taken(slot_ctr);
    assign target = hit ? {slot_tgt, 2'b00} : '0;
    assign next_pc = taken ? target : seq_pc;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_pc,
    input  logic              wb_taken,
    input  logic [ADDR_W-1:0] wb_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - 2;
    localparam int TGT_W = ADDR_W - 2;

    logic [IDX_W-1:0] f_idx, w_idx;
    logic [TAG_W-1:0] f_tag, w_tag;

    logic             rf_valid, rw_valid;
    logic [TAG_W-1:0] rf_tag, rw_tag;
    logic [TGT_W-1:0] rf_tgt, rw_tgt;
    btb_pkg::ctr_t    rf_ctr, rw_ctr;

    logic               st_we;
    logic [TAG_W-1:0]   st_tag;
    logic [TGT_W-1:0]   st_tgt;
    btb_pkg::ctr_t      st_ctr;
    btb_pkg::upd_kind_e upd_kind;

    logic [TGT_W-1:0] wb_tgt_word;
    logic             unused_tgt_low;

    assign wb_tgt_word    = wb_target[ADDR_W-1:2];
    assign unused_tgt_low = ^{wb_target[1:0], upd_kind};

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_fetch (
        .pc  (fetch_pc),
        .idx (f_idx),
        .tag (f_tag)
    );

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_wb (
        .pc  (wb_pc),
        .idx (w_idx),
        .tag (w_tag)
    );

    btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (st_we),
        .w_idx    (w_idx),
        .w_tag    (st_tag),
        .w_tgt    (st_tgt),
        .w_ctr    (st_ctr),
        .rf_idx   (f_idx),
        .rf_valid (rf_valid),
        .rf_tag   (rf_tag),
        .rf_tgt   (rf_tgt),
        .rf_ctr   (rf_ctr),
        .rw_idx   (w_idx),
        .rw_valid (rw_valid),
        .rw_tag   (rw_tag),
        .rw_tgt   (rw_tgt),
        .rw_ctr   (rw_ctr)
    );

    btb_train #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_train (
        .wb_valid  (wb_valid),
        .wb_taken  (wb_taken),
        .wb_tag    (w_tag),
        .wb_tgt    (wb_tgt_word),
        .cur_valid (rw_valid),
        .cur_tag   (rw_tag),
        .cur_tgt   (rw_tgt),
        .cur_ctr   (rw_ctr),
        .we        (st_we),
        .w_tag     (st_tag),
        .w_tgt     (st_tgt),
        .w_ctr     (st_ctr),
        .kind      (upd_kind)
    );

    btb_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_lookup (
        .fetch_pc   (fetch_pc),
        .fetch_tag  (f_tag),
        .slot_valid (rf_valid),
        .slot_tag   (rf_tag),
        .slot_tgt   (rf_tgt),
        .slot_ctr   (rf_ctr),
        .hit        (pred_hit),
        .taken      (pred_taken),
        .target     (pred_target),
        .next_pc    (pred_next_pc)
    );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_target,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              wb_valid,
    input logic [ADDR_W-1:0] wb_pc,
    input logic              wb_taken,
    input logic [ADDR_W-1:0] wb_target
);
    // R3: a miss predicts sequential fetch with no target
    p_miss_seq_r3: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (!pred_taken && pred_target == '0
                       && pred_next_pc == fetch_pc + ADDR_W'(4)));

    // R8: a known branch predicted not taken still falls through
    p_hit_nt_seq_r8: assert property (@(posedge clk) disable iff (rst)
        (pred_hit && !pred_taken) |-> (pred_next_pc == fetch_pc + ADDR_W'(4)));

    // R4: taken resolution of an unknown address is visible next cycle
    p_alloc_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_taken && wb_pc == fetch_pc && !pred_hit) |=>
        (!$stable(fetch_pc) ||
         (pred_hit && pred_taken && pred_target == {$past(wb_target[ADDR_W-1:2]), 2'b00})));

    // R5: not-taken resolution of an unknown address allocates nothing
    p_no_alloc_r5: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_taken && wb_pc == fetch_pc && !pred_hit) |=>
        (!$stable(fetch_pc) || !pred_hit));

    // R11: without a resolution a steady fetch address sees steady outputs
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !wb_valid |=>
        (!$stable(fetch_pc) ||
         ($stable(pred_hit) && $stable(pred_taken) && $stable(pred_target))));
endmodule

bind btb_predictor btb_checker #(.ADDR_W(ADDR_W)) u_btb_checker (
    .clk          (clk),
    .rst          (rst),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_taken   (pred_taken),
    .pred_target  (pred_target),
    .pred_next_pc (pred_next_pc),
    .wb_valid     (wb_valid),
    .wb_pc        (wb_pc),
    .wb_taken     (wb_taken),
    .wb_target    (wb_target)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int WATCHDOG   = 20000;

    localparam logic [31:0] PA = 32'h0000_1040; // slot 16, tag 0x10
    localparam logic [31:0] PB = 32'h0000_1140; // slot 16, tag 0x11
    localparam logic [31:0] PC = 32'h2000_0004; // slot 1
    localparam logic [31:0] PD = 32'h0000_0800; // slot 0
    localparam logic [31:0] PE = 32'h0000_0A0C; // slot 3
    localparam logic [31:0] T1 = 32'h0000_2000;
    localparam logic [31:0] T2 = 32'h0000_3000;
    localparam logic [31:0] T3 = 32'h0000_4440;
    localparam logic [31:0] T4 = 32'h0000_5008;

    typedef struct packed {
        logic        wbv;
        logic [31:0] wbpc;
        logic        wbt;
        logic [31:0] wbtg;
        logic [31:0] fpc;
        logic        ehit;
        logic        etkn;
        logic [31:0] etgt;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, 1'b0, 32'h0, 8'd2},  // R2 R3 empty after reset
        '{1'b1, PA, 1'b0, T1, PA, 1'b0, 1'b0, 32'h0, 8'd5},        // R5 not-taken miss
        '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b1, T1, 8'd4},           // R4 allocate at 10
        '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b1, T1, 8'd6},           // R6 10 -> 11
        '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b1, T1, 8'd6},           // R6 saturate at 11
        '{1'b1, PA, 1'b0, T2, PA, 1'b1, 1'b1, T1, 8'd7},           // R7 11 -> 10 still taken, R9 target kept
        '{1'b1, PA, 1'b0, T2, PA, 1'b1, 1'b0, T1, 8'd7},           // R7 R8 10 -> 01 flips
        '{1'b1, PA, 1'b0, T1, PA, 1'b1, 1'b0, T1, 8'd6},           // R6 01 -> 00
        '{1'b1, PA, 1'b0, T1, PA, 1'b1, 1'b0, T1, 8'd6},           // R6 saturate at 00
        '{1'b1, PA, 1'b1, T2, PA, 1'b1, 1'b0, T2, 8'd9},           // R9 target replaced, 00 -> 01
        '{1'b1, PA, 1'b1, T2, PA, 1'b1, 1'b1, T2, 8'd7},           // R7 01 -> 10 flips to taken
        '{1'b0, 32'h0, 1'b0, 32'h0, PB, 1'b0, 1'b0, 32'h0, 8'd1},  // R1 alias tag mismatch
        '{1'b1, PB, 1'b1, T3, PB, 1'b1, 1'b1, T3, 8'd10},          // R10 evicting allocation
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, 1'b0, 32'h0, 8'd10}, // R10 old owner misses
        '{1'b1, PC, 1'b1, T4, PC, 1'b1, 1'b1, T4, 8'd1},           // R1 other slot
        '{1'b0, 32'h0, 1'b0, 32'h0, PB, 1'b1, 1'b1, T3, 8'd1}      // R1 slots independent
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] fetch_pc = '0;
    logic              pred_hit, pred_taken;
    logic [ADDR_W-1:0] pred_target, pred_next_pc;
    logic              wb_valid = 1'b0;
    logic [ADDR_W-1:0] wb_pc = '0;
    logic              wb_taken = 1'b0;
    logic [ADDR_W-1:0] wb_target = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_predictor #(.ADDR_W(ADDR_W), .ENTRIES(64)) dut (
        .clk          (clk),
        .rst          (rst),
        .fetch_pc     (fetch_pc),
        .pred_hit     (pred_hit),
        .pred_taken   (pred_taken),
        .pred_target  (pred_target),
        .pred_next_pc (pred_next_pc),
        .wb_valid     (wb_valid),
        .wb_pc        (wb_pc),
        .wb_taken     (wb_taken),
        .wb_target    (wb_target)
    );

    task automatic expect_pred(input logic eh, input logic et,
                               input logic [31:0] etg, input int req);
        logic [31:0] enext;
        enext = et ? etg : fetch_pc + 32'd4;
        n_tests++;
        if (pred_hit !== eh || pred_taken !== et || pred_target !== etg
            || pred_next_pc !== enext) begin
            n_fail++;
            $display("FAIL R%0d pc=%h: hit/taken/target/next got %b/%b/%h/%h expected %b/%b/%h/%h",
                     req, fetch_pc, pred_hit, pred_taken, pred_target, pred_next_pc,
                     eh, et, etg, enext);
        end
    endtask

    // Present one resolution with the given fetch address, let one edge pass
    task automatic step(input logic v, input logic [31:0] p, input logic t,
                        input logic [31:0] tg, input logic [31:0] f);
        @(negedge clk);
        wb_valid  = v;
        wb_pc     = p;
        wb_taken  = t;
        wb_target = tg;
        fetch_pc  = f;
        @(posedge clk);
        #1;
        wb_valid = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].wbv, VECS[i].wbpc, VECS[i].wbt, VECS[i].wbtg, VECS[i].fpc);
            expect_pred(VECS[i].ehit, VECS[i].etkn, VECS[i].etgt, int'(VECS[i].req));
        end

        // R11: same-cycle lookup sees old contents, next cycle sees the write
        @(negedge clk);
        wb_valid  = 1'b1;
        wb_pc     = PD;
        wb_taken  = 1'b1;
        wb_target = T4;
        fetch_pc  = PD;
        #1;
        expect_pred(1'b0, 1'b0, 32'h0, 11); // R11 before edge
        @(posedge clk);
        #1;
        wb_valid = 1'b0;
        @(negedge clk);
        expect_pred(1'b1, 1'b1, T4, 11);    // R11 after edge

        // R12: alternating branch mispredicts every time from weakly taken
        begin
            int mispred;
            logic outcome;
            mispred = 0;
            step(1'b1, PE, 1'b1, T2, PE);
            outcome = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (pred_taken !== outcome) mispred++;
                step(1'b1, PE, outcome, T2, PE);
                outcome = ~outcome;
            end
            n_tests++;
            if (mispred != 6) begin
                n_fail++;
                $display("FAIL R12 alternating mispredictions got %0d expected 6", mispred);
            end
        end

        // R2: reset empties every slot
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        fetch_pc = PB;
        #1;
        expect_pred(1'b0, 1'b0, 32'h0, 2); // R2 slot 16
        fetch_pc = PC;
        #1;
        expect_pred(1'b0, 1'b0, 32'h0, 2); // R2 slot 1
        fetch_pc = PE;
        #1;
        expect_pred(1'b0, 1'b0, 32'h0, 2); // R2 slot 3

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule